// File: doc/BRIEF.md
# Configurable CRC Calculation Unit

This block computes a cyclic redundancy check over a stream of 32-bit words that software writes through a simple register bus. Each word written to the data register is folded into a running remainder in one clock cycle. The remainder can then be read back from the same address.

The generator polynomial is a software register. Its degree can be chosen at run time as 32, 16, 8 or 7 bits. The word can be bit-mirrored before it is folded, in one of three ways: inside each byte, inside each 16-bit half, or across the whole word. A separate control bit mirrors the remainder as it is read out. The starting value of the remainder comes from a programmable seed register and is reloaded by a reset command in the control register. An 8-bit scratch register sits beside the engine and has no effect on it.

Bus writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from the current register state. Only full 32-bit accesses exist.

Top module: `crc_unit`

## Requirements
- R1: After `rst_n` is released, the registers read as follows: data 0xFFFFFFFF, scratch 0, control 0, seed 0xFFFFFFFF, polynomial 0x04C11DB7.
- R2: The degree field is control bits 4:3, with 0 selecting 32 bits. With degree 32, no input mirroring and no output mirroring, a write to offset 0x00 replaces the remainder r with the result of folding the 32 bits MSB first. For each bit b, taken from bit 31 down to bit 0, let f = r[31] xor b; shift r left by one; if f is 1, xor the polynomial into r. No final xor is applied, and the new remainder reads back at offset 0x00 on the next cycle.
- R3: Control bits 4:3 select the degree as 0=32, 1=16, 2=8, 3=7. Only the low degree bits of the polynomial and the seed take part. The remainder reads zero-extended above the degree.
- R4: Control bits 6:5 select input mirroring before the fold: 0 none, 1 within each byte, 2 within each 16-bit half, 3 across all 32 bits.
- R5: When control bit 7 is 1, a read at offset 0x00 returns the remainder bit-reversed within the degree width, zero-extended.
- R6: Writing control (offset 0x08) with bit 0 set loads the remainder from the seed, masked to the new degree, on that clock edge. Control bit 0 always reads 0.
- R7: The scratch register at offset 0x04 stores bits 7:0, reads 0 in bits 31:8, and never changes the remainder.
- R8: The seed (offset 0x10) and the polynomial (offset 0x14) are 32-bit read/write registers.
- R9: Data writes on consecutive cycles each fold one word, with no cycle lost between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (0 when unmapped) |

## Verification
A remainder that is folded wrongly, or loaded from the wrong seed, corrupts the data-register value on the very next read. Because no later write can repair it, the error also shows on every read after that until the next reset command. A degree or mirroring field that is decoded wrongly shows in the first read after the first word folded under that mode. Each degree is therefore crossed with every input-mirroring mode and both output modes, and the result is compared with an independent bit-serial model. A scratch write that leaks into the engine shows as a changed data read right after that write.

// File: rtl/crc_pkg.sv
// Shared types and helpers for the CRC unit.
// Assumes a 32-bit data path; degree codes follow the control field encoding.
package crc_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        DEG_32 = 2'd0,
        DEG_16 = 2'd1,
        DEG_8  = 2'd2,
        DEG_7  = 2'd3
    } crc_deg_e;

    typedef enum logic [1:0] {
        MIR_NONE = 2'd0,
        MIR_BYTE = 2'd1,
        MIR_HALF = 2'd2,
        MIR_WORD = 2'd3
    } crc_mir_e;

    // Width in bits for a degree code.
    function automatic int deg_width(crc_deg_e d);
        case (d)
            DEG_32:  return 32;
            DEG_16:  return 16;
            DEG_8:   return 8;
            default: return 7;
        endcase
    endfunction

    // Mask of the active remainder bits for a degree code.
    function automatic logic [DATA_W-1:0] deg_mask(crc_deg_e d);
        case (d)
            DEG_32:  return 32'hFFFF_FFFF;
            DEG_16:  return 32'h0000_FFFF;
            DEG_8:   return 32'h0000_00FF;
            default: return 32'h0000_007F;
        endcase
    endfunction
endpackage

// File: rtl/crc_in_reflect.sv
// Input mirroring stage: reverses bit order inside each byte, each half,
// or the whole word, as the mode selects. Purely combinational.
// Assumes W is a multiple of 16.
module crc_in_reflect
    import crc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] din,
    input  crc_mir_e     mode,
    output logic [W-1:0] dout
);
    localparam int NBYTE = W / 8;
    localparam int NHALF = W / 16;

    logic [W-1:0] by_byte;
    logic [W-1:0] by_half;
    logic [W-1:0] by_word;

    // Per-byte mirror lanes.
    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        for (genvar b = 0; b < 8; b++) begin : g_bit
            assign by_byte[g*8 + b] = din[g*8 + 7 - b];
        end
    end

    // Per-half mirror lanes.
    for (genvar g = 0; g < NHALF; g++) begin : g_half
        for (genvar b = 0; b < 16; b++) begin : g_bit
            assign by_half[g*16 + b] = din[g*16 + 15 - b];
        end
    end

    // Whole-word mirror.
    for (genvar b = 0; b < W; b++) begin : g_word
        assign by_word[b] = din[W-1-b];
    end

    // Select the mirrored form requested by the mode field.
    always_comb begin
        case (mode)
            MIR_BYTE: dout = by_byte;
            MIR_HALF: dout = by_half;
            MIR_WORD: dout = by_word;
            default:  dout = din;
        endcase
    end
endmodule

// File: rtl/crc_fold.sv
// Single-cycle fold of one word into the remainder, MSB first, for the
// selected degree. The unrolled loop becomes a parallel XOR network.
// Assumes rem_in is already masked to the degree; output is masked too.
module crc_fold
    import crc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] word,
    input  logic [W-1:0] poly,
    input  crc_deg_e     deg,
    output logic [W-1:0] rem_out
);
    logic [W-1:0] msk;
    int           top;

    // Unrolled shift-and-xor over every word bit.
    always_comb begin
        logic [W-1:0] r;
        logic         fb;
        msk = deg_mask(deg);
        top = deg_width(deg) - 1;
        r   = rem_in & msk;
        for (int i = W - 1; i >= 0; i--) begin
            fb = r[top] ^ word[i];
            r  = (r << 1) & msk;
            if (fb) begin
                r = r ^ (poly & msk);
            end
        end
        rem_out = r;
    end
endmodule

// File: rtl/crc_out_reflect.sv
// Read-side formatting of the remainder: masks to the degree and, when
// enabled, mirrors the bits within that width. Zero-extends the result.
module crc_out_reflect
    import crc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] rem,
    input  crc_deg_e     deg,
    input  logic         mirror,
    output logic [W-1:0] dout
);
    logic [W-1:0] rev;

    // Full-width mirror, later shifted down to the degree.
    for (genvar b = 0; b < W; b++) begin : g_rev
        assign rev[b] = rem[W-1-b];
    end

    // Pick plain or mirrored view of the active bits.
    always_comb begin
        if (mirror) begin
            dout = (rev >> (W - deg_width(deg))) & deg_mask(deg);
        end else begin
            dout = rem & deg_mask(deg);
        end
    end
endmodule

// File: rtl/crc_unit.sv
// Register-mapped CRC engine. Holds the seed, polynomial, control, scratch
// and remainder registers, decodes the bus and folds data writes in one
// cycle. Assumes full 32-bit accesses and at most one access per cycle.
module crc_unit
    import crc_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(5'h00);
    localparam logic [ADDR_W-1:0] OFS_SCR  = ADDR_W'(5'h04);
    localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(5'h08);
    localparam logic [ADDR_W-1:0] OFS_SEED = ADDR_W'(5'h10);
    localparam logic [ADDR_W-1:0] OFS_POLY = ADDR_W'(5'h14);
    localparam int                SCR_W    = 8;

    logic [DATA_W-1:0] rem_q;
    logic [DATA_W-1:0] init_q;
    logic [DATA_W-1:0] poly_q;
    logic [SCR_W-1:0]  scr_q;
    crc_deg_e          deg_q;
    crc_mir_e          mir_q;
    logic              omir_q;

    logic              wr_en;
    logic              wr_data, wr_scr, wr_ctl, wr_seed, wr_poly;
    crc_deg_e          new_deg;
    logic [DATA_W-1:0] mirrored;
    logic [DATA_W-1:0] folded;
    logic [DATA_W-1:0] data_view;

    // Write strobes per register.
    assign wr_en   = bus_sel && bus_wr;
    assign wr_data = wr_en && (bus_addr == OFS_DATA);
    assign wr_scr  = wr_en && (bus_addr == OFS_SCR);
    assign wr_ctl  = wr_en && (bus_addr == OFS_CTL);
    assign wr_seed = wr_en && (bus_addr == OFS_SEED);
    assign wr_poly = wr_en && (bus_addr == OFS_POLY);
    assign new_deg = crc_deg_e'(bus_wdata[4:3]);

    crc_in_reflect #(.W(DATA_W)) u_in (
        .din  (bus_wdata),
        .mode (mir_q),
        .dout (mirrored)
    );

    crc_fold #(.W(DATA_W)) u_fold (
        .rem_in  (rem_q),
        .word    (mirrored),
        .poly    (poly_q),
        .deg     (deg_q),
        .rem_out (folded)
    );

    crc_out_reflect #(.W(DATA_W)) u_out (
        .rem    (rem_q),
        .deg    (deg_q),
        .mirror (omir_q),
        .dout   (data_view)
    );

    // Configuration and scratch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= SEED_RST;
            poly_q <= POLY_RST;
            scr_q  <= '0;
            deg_q  <= DEG_32;
            mir_q  <= MIR_NONE;
            omir_q <= 1'b0;
        end else begin
            if (wr_seed) init_q <= bus_wdata;
            if (wr_poly) poly_q <= bus_wdata;
            if (wr_scr)  scr_q  <= bus_wdata[SCR_W-1:0];
            if (wr_ctl) begin
                deg_q  <= new_deg;
                mir_q  <= crc_mir_e'(bus_wdata[6:5]);
                omir_q <= bus_wdata[7];
            end
        end
    end

    // Running remainder: reload on reset command, fold on data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= SEED_RST;
        end else if (wr_ctl && bus_wdata[0]) begin
            rem_q <= init_q & deg_mask(new_deg);
        end else if (wr_data) begin
            rem_q <= folded;
        end
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_DATA: bus_rdata = data_view;
                OFS_SCR:  bus_rdata = {{(DATA_W-SCR_W){1'b0}}, scr_q};
                OFS_CTL:  bus_rdata = {24'd0, omir_q, mir_q, deg_q, 3'b000};
                OFS_SEED: bus_rdata = init_q;
                OFS_POLY: bus_rdata = poly_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/crc_unit_chk.sv
// Property checker for crc_unit, attached by bind. Observes the bus and
// the internal register state; drives nothing.
module crc_unit_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       rem_q,
    input logic [31:0]       init_q,
    input logic [31:0]       poly_q,
    input logic [1:0]        deg_q
);
    logic rd, wr;
    assign rd = bus_sel && !bus_wr;
    assign wr = bus_sel && bus_wr;

    AST_CTL_RST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_W'(5'h08)) |-> (bus_rdata[0] == 1'b0)); // R6

    AST_RESET_LOADS_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(5'h08) && bus_wdata[0] && bus_wdata[4:3] == 2'd0)
        |=> (rem_q == $past(init_q))); // R6

    AST_SCRATCH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_W'(5'h04)) |-> (bus_rdata[31:8] == 24'd0)); // R7

    AST_SCRATCH_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(5'h04)) |=> $stable(rem_q)); // R7

    AST_DATA_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_W'(5'h00) && deg_q != 2'd0) |-> (bus_rdata[31:16] == 16'd0)); // R3

    AST_POLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(5'h14)) |=> (poly_q == $past(bus_wdata))); // R8
endmodule

bind crc_unit crc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rem_q     (rem_q),
    .init_q    (init_q),
    .poly_q    (poly_q),
    .deg_q     (deg_q)
);

// File: tb/tb_crc_unit.sv
// Scoreboard bench: the driver pushes expected read values into a queue,
// and the monitor pops them and compares them at mid-cycle.
module tb_crc_unit;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    always #5 clk = ~clk;

    crc_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench mirror of the programmer-visible state.
    logic [31:0] m_rem = 32'hFFFF_FFFF;
    logic [31:0] m_seed = 32'hFFFF_FFFF;
    logic [31:0] m_poly = 32'h04C1_1DB7;
    int          m_deg = 0;
    int          m_mir = 0;
    bit          m_omir = 0;

    function automatic int wid(int d);
        return (d == 0) ? 32 : (d == 1) ? 16 : (d == 2) ? 8 : 7;
    endfunction

    function automatic logic [31:0] msk(int d);
        return (wid(d) == 32) ? 32'hFFFF_FFFF : ((32'd1 << wid(d)) - 32'd1);
    endfunction

    // Input mirroring by swapping bits within groups of size g.
    function automatic logic [31:0] mir_in(logic [31:0] w, int mode);
        logic [31:0] o;
        int g;
        if (mode == 0) return w;
        g = (mode == 1) ? 8 : (mode == 2) ? 16 : 32;
        o = '0;
        for (int k = 0; k < 32; k++) begin
            int base;
            base = (k / g) * g;
            o[base + (g - 1 - (k - base))] = w[k];
        end
        return o;
    endfunction

    // Bit-serial reference fold.
    function automatic logic [31:0] ref_fold(logic [31:0] r, logic [31:0] w,
                                             int d, logic [31:0] p);
        int n;
        logic [31:0] m;
        logic top;
        n = wid(d);
        m = msk(d);
        r = r & m;
        for (int k = 31; k >= 0; k--) begin
            top = r[n-1];
            r = (r << 1) & m;
            if (top != w[k]) r = r ^ (p & m);
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_view(logic [31:0] r, int d, bit om);
        logic [31:0] o;
        int n;
        n = wid(d);
        r = r & msk(d);
        if (!om) return r;
        o = '0;
        for (int k = 0; k < n; k++) o[n-1-k] = r[k];
        return o;
    endfunction

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        case (a)
            5'h00: m_rem = ref_fold(m_rem, mir_in(d, m_mir), m_deg, m_poly);
            5'h08: begin
                m_deg = int'(d[4:3]); m_mir = int'(d[6:5]); m_omir = d[7];
                if (d[0]) m_rem = m_seed & msk(m_deg);
            end
            5'h10: m_seed = d;
            5'h14: m_poly = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(logic [AW-1:0] a, logic [31:0] e, string tag);
        item_t it;
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = '0;
        it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic bus_idle();
        @(posedge clk); #2;
        bus_sel = 0; bus_wr = 0;
    endtask

    // Monitor: compare each read at mid-cycle against the queued item.
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && !done) begin
            item_t it;
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with empty queue, got %h", bus_rdata);
            end else begin
                it = q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1: reset state of every register.
        bus_read(5'h00, 32'hFFFF_FFFF, "R1 data");
        bus_read(5'h04, 32'h0, "R1 scratch");
        bus_read(5'h08, 32'h0, "R1 control");
        bus_read(5'h10, 32'hFFFF_FFFF, "R1 seed");
        bus_read(5'h14, 32'h04C1_1DB7, "R1 poly");

        // R6: reload from a zero seed; control bit 0 reads back 0.
        bus_write(5'h10, 32'h0);
        bus_write(5'h08, 32'h1);
        bus_read(5'h00, 32'h0, "R6 reload");
        bus_read(5'h08, 32'h0, "R6 self-clear");

        // R2: a single 1 in bit 0 with zero seed gives the polynomial.
        bus_write(5'h00, 32'h0000_0001);
        bus_read(5'h00, 32'h04C1_1DB7, "R2 known value");
        bus_write(5'h00, 32'hDEAD_BEEF);
        bus_read(5'h00, ref_view(m_rem, m_deg, m_omir), "R2 chained");

        // R3 R4 R5 R9: every degree x input mirror x output mirror.
        for (int d = 0; d < 4; d++) begin
            for (int mi = 0; mi < 4; mi++) begin
                for (int om = 0; om < 2; om++) begin
                    string t;
                    t = (d != 0) ? "R3" : (mi != 0) ? "R4" : (om != 0) ? "R5" : "R9";
                    bus_write(5'h10, 32'hA5C3_1E77 ^ (d * 32'h1111_0000));
                    bus_write(5'h14, (d == 0) ? 32'h04C1_1DB7 : (d == 1) ? 32'h0000_8005 :
                                     (d == 2) ? 32'h0000_0007 : 32'h0000_0009);
                    bus_write(5'h08, {24'd0, 1'(om), 2'(mi), 2'(d), 3'b001});
                    bus_read(5'h00, ref_view(m_rem, m_deg, m_omir), {t, " seed view"});
                    bus_write(5'h00, 32'h1234_5678 + mi);
                    bus_write(5'h00, 32'h8000_00F1);
                    bus_write(5'h00, 32'hCAFE_0B0E ^ (om * 32'h0F0F_0F0F));
                    bus_read(5'h00, ref_view(m_rem, m_deg, m_omir), {t, " folded"});
                end
            end
        end

        // R7: scratch stores 8 bits and leaves the remainder alone.
        bus_write(5'h08, 32'h0);
        bus_read(5'h00, ref_view(m_rem, m_deg, m_omir), "R7 before");
        bus_write(5'h04, 32'h1234_56AB);
        bus_read(5'h04, 32'h0000_00AB, "R7 scratch");
        bus_read(5'h00, ref_view(m_rem, m_deg, m_omir), "R7 remainder kept");

        // R8: full-width seed and polynomial.
        bus_write(5'h10, 32'h8765_4321);
        bus_write(5'h14, 32'hF0E1_D2C3);
        bus_read(5'h10, 32'h8765_4321, "R8 seed");
        bus_read(5'h14, 32'hF0E1_D2C3, "R8 poly");

        // R3: 7-bit degree with seed upper bits set reads zero-extended.
        bus_write(5'h08, 32'h19);
        bus_read(5'h00, 32'h0000_0021, "R3 seven bit mask");

        bus_idle();
        repeat (3) @(posedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d reads unseen expected 0", q.size());
        end
        finish_run();
    end
endmodule